// File: doc/BRIEF.md
# Converter Calibration and Power-Down Sequencer

This block is the control sequencer that sits beside a data converter's calibration engine and analog power switch. It decides, cycle by cycle, whether the converter is calibrating, ready, sleeping or refilling its output pipeline. Three sources compete: a level-sensitive sleep input, the automatic calibration that follows reset, and a software-style manual calibration request.

The sequencer arbitrates between these sources with fixed rules:
- A sleep request that arrives mid-calibration waits until the engine reports completion.
- The automatic calibration waits for sleep to be released.
- Manual requests made while asleep are thrown away.

After every wake-up, an output valid gate stays low for a fixed number of cycles so that stale pipeline contents never reach downstream logic. All state changes happen on clock edges only.

Top module: `conv_pwr_cal_seq`

## Requirements
- R1: While and after reset, `cal_run` = 0, `busy` = 0, `out_valid` = 0 and `pwr_dn` = 1.
- R2: Once out of reset with `pd_req` low, the first clock edge launches the automatic calibration. `cal_run` is high for exactly one cycle and `busy` is high with it.
- R3: If `pd_req` is high when reset ends, no calibration starts and `pwr_dn` stays 1 for as long as `pd_req` stays high. The calibration starts on the first edge at which `pd_req` is sampled low.
- R4: `busy` stays high from the `cal_run` cycle until the edge that samples `cal_done`. If `pd_req` is low at that edge, the block becomes ready and `out_valid` goes to 1.
- R5: When `pd_req` rises during a calibration, `pwr_dn` stays 0 and `busy` stays 1 until `cal_done` is sampled. On that same edge the block sleeps, with `pwr_dn` = 1 and `busy` = 0.
- R6: When the block is ready, a high `pd_req` sets `pwr_dn` = 1 and `out_valid` = 0 on the next edge.
- R7: A `cal_req` rise while asleep is discarded. No `cal_run` occurs while asleep, and none occurs after wake-up while `cal_req` is still held high.
- R8: Call the edge that first samples `pd_req` low after sleep edge 0. `out_valid` is 0 after edges 0 to PIPE_DEPTH-1 and is 1 after edge PIPE_DEPTH. A `pd_req` rise during this flush returns the block to sleep.
- R9: `cal_req` is edge-triggered. A request held high for any length of time produces at most one `cal_run` pulse.
- R10: A `cal_req` rise during a calibration is dropped. It does not retrigger and is not queued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter input clock; every state change occurs on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| pd_req | input | 1 | Power-down level; high asks for sleep |
| cal_req | input | 1 | Manual calibration request, rising-edge sensitive |
| cal_done | input | 1 | One-cycle completion pulse from the calibration engine |
| cal_run | output | 1 | One-cycle strobe that launches the calibration engine |
| busy | output | 1 | High while a calibration is in progress, including a deferred sleep |
| pwr_dn | output | 1 | Analog power-down enable |
| out_valid | output | 1 | Output data gate; low until the pipeline has been refilled |

## Verification
The directed patterns cover the following cases:
- Sleep held across reset, which separates a held-off power-on calibration from one that is simply late.
- Sleep raised in the middle of a calibration, which shows whether the power-down is deferred or taken at once.
- A manual request raised while asleep and then held through the wake-up, which exposes any request that is latched or level-triggered.
- Requests held during a calibration and a long held request, which distinguish edge detection from level detection and from retriggering.

The exact flush window is timed edge by edge to catch off-by-one counts. A long random phase then toggles sleep and request inputs at mixed rates, with a fixed seed, against a bench model. This reaches sleep during flush and interleavings that the directed cases do not.

// File: rtl/convseq_pkg.sv
package convseq_pkg;

  typedef enum logic [2:0] {
    ST_BOOT   = 3'd0,
    ST_CALIB  = 3'd1,
    ST_PDWAIT = 3'd2,
    ST_READY  = 3'd3,
    ST_SLEEP  = 3'd4,
    ST_FLUSH  = 3'd5
  } seq_state_t;

  // Last count value of a flush window of the given depth.
  function automatic int flush_last(input int depth);
    return depth - 1;
  endfunction

  // Counter width able to hold values 0..depth.
  function automatic int flush_width(input int depth);
    return (depth < 2) ? 1 : $clog2(depth + 1);
  endfunction

  function automatic logic is_calibrating(input seq_state_t s);
    return (s == ST_CALIB) || (s == ST_PDWAIT);
  endfunction

  function automatic logic is_powered_down(input seq_state_t s);
    return (s == ST_BOOT) || (s == ST_SLEEP);
  endfunction

endpackage

// File: rtl/convseq_req_edge.sv
module convseq_req_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic req_in,
  output logic req_rise
);
  logic req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_in;
  end

  assign req_rise = req_in & ~req_q;

  // A rise cannot repeat on consecutive edges (R9)
  assert_single_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_rise |=> !req_rise);

endmodule

// File: rtl/convseq_flush_timer.sv
module convseq_flush_timer
  import convseq_pkg::*;
#(
  parameter int PIPE_DEPTH = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  localparam int CW   = flush_width(PIPE_DEPTH);
  localparam int LAST = flush_last(PIPE_DEPTH);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (!last)  cnt <= cnt + CW'(1);
  end

  assign last = run && (cnt == CW'(LAST));

  // Count never passes the window end (R8)
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LAST));

endmodule

// File: rtl/convseq_fsm.sv
module convseq_fsm
  import convseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pd_req,
  input  logic req_rise,
  input  logic cal_done,
  input  logic flush_last_i,
  output logic flush_run,
  output logic cal_run,
  output logic busy,
  output logic pwr_dn,
  output logic out_valid
);
  seq_state_t state, nxt;
  logic cal_run_q;

  // Named internal events
  logic ev_start, ev_cal_end, ev_wake, ev_sleep;

  assign ev_start   = (state == ST_BOOT  && !pd_req) ||
                      (state == ST_READY && !pd_req && req_rise);
  assign ev_cal_end = is_calibrating(state) && cal_done;
  assign ev_wake    = (state == ST_SLEEP) && !pd_req;
  assign ev_sleep   = (nxt == ST_SLEEP) && (state != ST_SLEEP);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_BOOT:   if (!pd_req) nxt = ST_CALIB;
      ST_CALIB: begin
        if (cal_done)    nxt = pd_req ? ST_SLEEP : ST_READY;
        else if (pd_req) nxt = ST_PDWAIT;
      end
      ST_PDWAIT: begin
        if (cal_done)     nxt = pd_req ? ST_SLEEP : ST_READY;
        else if (!pd_req) nxt = ST_CALIB;
      end
      ST_READY: begin
        if (pd_req)        nxt = ST_SLEEP;
        else if (req_rise) nxt = ST_CALIB;
      end
      ST_SLEEP:  if (!pd_req) nxt = ST_FLUSH;
      ST_FLUSH: begin
        if (pd_req)            nxt = ST_SLEEP;
        else if (flush_last_i) nxt = ST_READY;
      end
      default:   nxt = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_BOOT;
      cal_run_q <= 1'b0;
    end else begin
      state     <= nxt;
      cal_run_q <= ev_start;
    end
  end

  assign flush_run = (state == ST_FLUSH);
  assign cal_run   = cal_run_q;
  assign busy      = is_calibrating(state);
  assign pwr_dn    = is_powered_down(state);
  assign out_valid = (state == ST_READY);

  // Strobe only accompanies an active calibration (R2)
  assert_strobe_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cal_run |-> busy);
  // Sleep held from boot keeps calibration off (R3)
  assert_boot_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BOOT && pd_req) |=> (!cal_run && pwr_dn));
  // Sleep request mid-calibration is deferred (R5)
  assert_defer_pd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pd_req && !cal_done) |=> (busy && !pwr_dn));
  // Nothing launches out of sleep (R7)
  assert_sleep_no_cal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP) |=> !cal_run);
  // Valid stays gated within the flush window (R8)
  assert_flush_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FLUSH && !flush_last_i) |=> !out_valid);
  // Entering sleep drops valid (R6)
  assert_sleep_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sleep |=> (pwr_dn && !out_valid));
  // Completion ends busy (R4)
  assert_cal_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cal_end |=> !busy);
  // Wake always enters the flush window (R8)
  assert_wake_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wake |=> (flush_run && !pwr_dn));

endmodule

// File: rtl/conv_pwr_cal_seq.sv
module conv_pwr_cal_seq
  import convseq_pkg::*;
#(
  parameter int PIPE_DEPTH = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_req,
  input  logic cal_req,
  input  logic cal_done,
  output logic cal_run,
  output logic busy,
  output logic pwr_dn,
  output logic out_valid
);
  logic req_rise;
  logic flush_run;
  logic flush_last_w;

  convseq_req_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_in   (cal_req),
    .req_rise (req_rise)
  );

  convseq_flush_timer #(.PIPE_DEPTH(PIPE_DEPTH)) u_flush (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (flush_run),
    .last  (flush_last_w)
  );

  convseq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .pd_req       (pd_req),
    .req_rise     (req_rise),
    .cal_done     (cal_done),
    .flush_last_i (flush_last_w),
    .flush_run    (flush_run),
    .cal_run      (cal_run),
    .busy         (busy),
    .pwr_dn       (pwr_dn),
    .out_valid    (out_valid)
  );

  // A calibrating converter is never powered down (R5)
  assert_busy_powered_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !pwr_dn);
  // Valid data never coexists with calibration or sleep (R4)
  assert_valid_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!busy && !pwr_dn));
  // A request seen during calibration does not launch (R10)
  assert_no_retrigger_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_rise) |=> !cal_run);

endmodule

// File: tb/conv_pwr_cal_seq_test.sv
module conv_pwr_cal_seq_test;
  localparam int PIPE_DEPTH = 6;
  localparam int CAL_LEN    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_req = 1'b0, cal_req = 1'b0, cal_done = 1'b0;
  logic cal_run, busy, pwr_dn, out_valid;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  bit model_en = 0;

  always #2 clk = ~clk;  // 250 MHz

  conv_pwr_cal_seq #(.PIPE_DEPTH(PIPE_DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .cal_req(cal_req),
    .cal_done(cal_done), .cal_run(cal_run), .busy(busy),
    .pwr_dn(pwr_dn), .out_valid(out_valid)
  );

  // Calibration engine stand-in: fixed-length counter
  int eng_cnt = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      eng_cnt  <= 0;
      cal_done <= 1'b0;
    end else begin
      cal_done <= 1'b0;
      if (cal_run) eng_cnt <= CAL_LEN;
      else if (eng_cnt != 0) begin
        eng_cnt <= eng_cnt - 1;
        if (eng_cnt == 1) cal_done <= 1'b1;
      end
    end
  end

  // Bench model: 0 boot, 1 calibrating, 2 ready, 3 asleep, 4 flushing
  int m_mode = 0, m_fc = 0;
  bit m_prev = 0, m_strobe = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_fc = 0; m_prev = 0; m_strobe = 0;
    end else begin
      automatic bit rise = cal_req && !m_prev;
      m_prev   = cal_req;
      m_strobe = 0;
      case (m_mode)
        0: if (!pd_req) begin m_mode = 1; m_strobe = 1; end
        1: if (cal_done) m_mode = pd_req ? 3 : 2;
        2: if (pd_req) m_mode = 3;
           else if (rise) begin m_mode = 1; m_strobe = 1; end
        3: if (!pd_req) begin m_mode = 4; m_fc = 0; end
        default: if (pd_req) m_mode = 3;
                 else if (m_fc == PIPE_DEPTH - 1) m_mode = 2;
                 else m_fc = m_fc + 1;
      endcase
    end
  end

  function automatic bit exp_pwr(input int mode);
    return (mode == 0) || (mode == 3);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_en && rst_n) begin
      check(cal_run == m_strobe, "R2 model cal_run", cal_run, m_strobe);
      check(busy == (m_mode == 1), "R4 model busy", busy, m_mode == 1);
      check(pwr_dn == exp_pwr(m_mode), "R5 model pwr_dn", pwr_dn, exp_pwr(m_mode));
      check(out_valid == (m_mode == 2), "R8 model out_valid", out_valid, m_mode == 2);
    end
  end

  task automatic wait_idle(output bit ok);
    ok = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!busy) begin ok = 1; break; end
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    bit ok;
    int pulses;
    void'($urandom(32'd20240611));
    // R1 / R3: sleep held through reset
    pd_req = 1'b1;
    repeat (3) @(negedge clk);
    check(cal_run == 0 && busy == 0 && out_valid == 0 && pwr_dn == 1,
          "R1 reset outputs", {cal_run, busy, out_valid, pwr_dn}, 4'b0001);
    rst_n = 1'b1;
    model_en = 1;
    pulses = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (cal_run || busy || !pwr_dn) pulses++;
    end
    check(pulses == 0, "R3 held off under sleep", pulses, 0);
    // R2: release sleep, calibration launches on first edge
    pd_req = 1'b0;
    @(negedge clk);
    check(cal_run == 1 && busy == 1, "R2 launch strobe", {cal_run, busy}, 2'b11);
    // R10: request held during calibration
    cal_req = 1'b1;
    @(negedge clk);
    check(cal_run == 0, "R2 strobe one cycle", cal_run, 0);
    wait_idle(ok);
    check(ok && out_valid == 1, "R4 calibration completes to ready", out_valid, 1);
    pulses = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (cal_run) pulses++;
    end
    check(pulses == 0, "R10 request during calibration dropped", pulses, 0);
    cal_req = 1'b0;
    @(negedge clk);
    // R9: long held request yields a single calibration
    cal_req = 1'b1;
    pulses = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (cal_run) pulses++;
    end
    check(pulses == 1, "R9 held request one pulse", pulses, 1);
    cal_req = 1'b0;
    @(negedge clk);
    // R5: sleep requested mid-calibration
    cal_req = 1'b1;
    @(negedge clk);
    check(cal_run == 1, "R9 new rise launches", cal_run, 1);
    cal_req = 1'b0;
    pd_req  = 1'b1;
    pulses = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!busy) break;
      if (pwr_dn) pulses++;
    end
    check(pulses == 0, "R5 power stays on while calibrating", pulses, 0);
    check(pwr_dn == 1 && busy == 0, "R5 sleep after completion", {pwr_dn, busy}, 2'b10);
    // R7: request while asleep, held through wake
    cal_req = 1'b1;
    pulses = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (cal_run || !pwr_dn) pulses++;
    end
    check(pulses == 0, "R7 no calibration while asleep", pulses, 0);
    // R8: flush window timing
    pd_req = 1'b0;
    pulses = 0;
    for (int i = 0; i < PIPE_DEPTH; i++) begin
      @(negedge clk);
      if (out_valid) pulses++;
    end
    check(pulses == 0, "R8 valid gated during flush", pulses, 0);
    @(negedge clk);
    check(out_valid == 1, "R8 valid after flush", out_valid, 1);
    pulses = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (cal_run) pulses++;
    end
    check(pulses == 0, "R7 discarded request not replayed", pulses, 0);
    cal_req = 1'b0;
    // R6: sleep from ready
    pd_req = 1'b1;
    @(negedge clk);
    check(pwr_dn == 1 && out_valid == 0, "R6 sleep from ready", {pwr_dn, out_valid}, 2'b10);
    // R8: sleep re-asserted mid-flush returns to sleep
    pd_req = 1'b0;
    repeat (2) @(negedge clk);
    pd_req = 1'b1;
    @(negedge clk);
    check(pwr_dn == 1 && out_valid == 0, "R8 sleep during flush", {pwr_dn, out_valid}, 2'b10);
    // Random phase checked against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom_range(39, 0) == 0) pd_req = ~pd_req;
      if ($urandom_range(5, 0) == 0)  cal_req = ~cal_req;
    end
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule